// File: doc/BRIEF.md
# SPI Master Chip-Select Delay Sequencer

This block is the transfer-sequencing core of an SPI master with four active-low peripheral selects. Words arrive through a one-entry holding register. Each word is routed to one select, which comes either from a fixed mode setting or from a select field packed into the word. The block then shifts the word out MSB first on a mode-0 style serial clock. Each bit takes two system clock cycles: one with the clock low and one with the clock high.

The sequencer inserts programmable waits at three points, all counted in system clock cycles. The first is a per-select wait after a select falls and before its first clock rise. The second is a per-select gap after each word on a select. The third is a single wait after any select is released, before a select may fall again. A per-select keep option holds a select low across words. A select is released after a word in four cases: that word carries the last-transfer flag, the next word targets another select, keep is off, or a disable command was given. A release never happens in the middle of a word.

Top module: `spi_cs_seq`

## Requirements
- R1: Four active-low selects `cs_n`. At most one is low at any time, and all are high after reset and whenever no transfer or hold is in progress.
- R2: With `cfg_var_sel`=0 the target comes from `cfg_fixed_cs`, and the select field in the written word has no effect.
- R3: With `cfg_var_sel`=1 the target comes from the word. The word holds data in bits [DW-1:0] (sent MSB first), the select field in bits [DW+3:DW] and the last-transfer flag in bit DW+4. The field is decoded one-hot-low: value with only bit n cleared selects `cs_n[n]` (4'b1110 selects 0, 4'b0111 selects 3).
- R4: A select value that does not have exactly one bit cleared (for example 4'b1100 or 4'b1111) drops the word. No select falls and no clock pulse appears for it.
- R5: The first clock rise of a word follows the fall of its select by max(P,1)+1 cycles, where P is that select's `cfg_dly_pre` slice.
- R6: When keep is set and the next word for the same select is already waiting, its first clock rise comes G+3 cycles after the previous word's last rise, where G is that select's `cfg_dly_gap` slice. The select stays low throughout.
- R7: After a select rises, all selects stay high for C+1 cycles before the next one falls (with a word waiting), where C is `cfg_dly_cs`.
- R8: With keep clear, the select rises after every word.
- R9: A word with the last-transfer flag set releases its select after it finishes, even when keep is set.
- R10: A one-cycle `cmd_dis` pulse releases the active select after the current word completes. This includes a pulse in the very cycle of the final clock-high phase. While holding between words, the select is released on the next cycle.
- R11: `tx_rdy` is high exactly when the holding register is empty, and a write while it is low is ignored. `tx_empty` is high only when no word is waiting, nothing is shifting and no gap or release wait is running; it is also high while a select is held low between words.
- R12: `sclk` idles low. Each bit has one low cycle followed by one high cycle, and `mosi` carries the bit during the high cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_var_sel | input | 1 | 1: target taken from each word; 0: target from `cfg_fixed_cs` |
| cfg_fixed_cs | input | 4 | One-hot-low target used when `cfg_var_sel`=0 |
| cfg_keep | input | 4 | Per-select keep-asserted option |
| cfg_dly_pre | input | 4*DLYW | Per-select wait from select fall to first clock |
| cfg_dly_gap | input | 4*DLYW | Per-select gap after each word |
| cfg_dly_cs | input | DLYW | Wait after any select release |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_word | input | DW+5 | {last, select field, data} |
| cmd_dis | input | 1 | Disable pulse: release after the current word |
| tx_rdy | output | 1 | Holding register empty |
| tx_empty | output | 1 | Nothing waiting, shifting or timing |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 4 | Active-low peripheral selects |

## Verification
Two things can land in the same cycle: the disable command and the final clock-high phase of a word, and both feed the release decision. The bench counts the clock-high cycles itself and pulses `cmd_dis` on exactly the eighth one, with keep set so that only the command can cause a release. It then requires the select to be high on the very next cycle, and requires the word that was shifting to have arrived intact. A second case issues the command while the select is held between words; there the release must follow at once, with no clock pulse.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
    localparam int NCS = 4;
    localparam int CSW = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SHIFT,
        ST_GAP,
        ST_HOLD,
        ST_DESEL
    } seq_st_e;
endpackage

// File: rtl/spi_cs_decode.sv
module spi_cs_decode
    import spi_seq_pkg::*;
(
    input  logic [NCS-1:0] field,
    output logic           valid,
    output logic [CSW-1:0] idx
);
    always_comb begin
        valid = ($countones(~field) == 1);
        idx   = '0;
        for (int i = 0; i < NCS; i++) begin
            if (!field[i]) idx = CSW'(i);
        end
    end
endmodule

// File: rtl/spi_dly_pick.sv
module spi_dly_pick
    import spi_seq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [NCS*W-1:0] vec,
    input  logic [CSW-1:0]   idx,
    output logic [W-1:0]     val
);
    logic [W-1:0] slot [NCS];

    for (genvar g = 0; g < NCS; g++) begin : g_slot
        assign slot[g] = vec[g*W +: W];
    end

    assign val = slot[idx];
endmodule

// File: rtl/spi_cs_seq.sv
module spi_cs_seq
    import spi_seq_pkg::*;
#(
    parameter int DW   = 8,
    parameter int DLYW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_var_sel,
    input  logic [NCS-1:0]      cfg_fixed_cs,
    input  logic [NCS-1:0]      cfg_keep,
    input  logic [NCS*DLYW-1:0] cfg_dly_pre,
    input  logic [NCS*DLYW-1:0] cfg_dly_gap,
    input  logic [DLYW-1:0]     cfg_dly_cs,
    input  logic                wr_en,
    input  logic [DW+4:0]       wr_word,
    input  logic                cmd_dis,
    output logic                tx_rdy,
    output logic                tx_empty,
    output logic                sclk,
    output logic                mosi,
    output logic [NCS-1:0]      cs_n
);
    localparam int BW = (DW > 1) ? $clog2(DW) : 1;

    typedef struct packed {
        seq_st_e        st;
        logic [DLYW-1:0] cnt;
        logic [CSW-1:0] cur;
        logic           hold_v;
        logic [DW-1:0]  hold_data;
        logic [NCS-1:0] hold_sel;
        logic           hold_last;
        logic [DW-1:0]  sh;
        logic [BW-1:0]  bitc;
        logic           phase;
        logic           last;
        logic           dis;
    } seq_t;

    seq_t q, n;

    logic [NCS-1:0]  sel_field;
    logic            tgt_ok;
    logic [CSW-1:0]  tgt_idx;
    logic [DLYW-1:0] pre_val;
    logic [DLYW-1:0] gap_val;
    logic            dis_any;
    logic            post;
    logic            rel;

    assign sel_field = cfg_var_sel ? q.hold_sel : cfg_fixed_cs;

    spi_cs_decode u_dec (
        .field (sel_field),
        .valid (tgt_ok),
        .idx   (tgt_idx)
    );

    spi_dly_pick #(.W(DLYW)) u_pre (
        .vec (cfg_dly_pre),
        .idx (tgt_idx),
        .val (pre_val)
    );

    spi_dly_pick #(.W(DLYW)) u_gap (
        .vec (cfg_dly_gap),
        .idx (q.cur),
        .val (gap_val)
    );

    assign dis_any = q.dis | cmd_dis;

    always_comb begin
        n    = q;
        post = 1'b0;
        rel  = 1'b0;

        if (wr_en && !q.hold_v) begin
            n.hold_v    = 1'b1;
            n.hold_data = wr_word[DW-1:0];
            n.hold_sel  = wr_word[DW+3:DW];
            n.hold_last = wr_word[DW+4];
        end
        if (cmd_dis) n.dis = 1'b1;

        case (q.st)
            ST_IDLE: begin
                n.dis = 1'b0;
                if (q.hold_v) begin
                    n.hold_v = 1'b0;
                    if (tgt_ok) begin
                        n.st    = ST_PRE;
                        n.cur   = tgt_idx;
                        n.cnt   = (pre_val == '0) ? DLYW'(1) : pre_val;
                        n.sh    = q.hold_data;
                        n.last  = q.hold_last;
                        n.bitc  = BW'(DW - 1);
                        n.phase = 1'b0;
                    end
                end
            end
            ST_PRE: begin
                if (q.cnt <= DLYW'(1)) n.st = ST_SHIFT;
                else                   n.cnt = q.cnt - DLYW'(1);
            end
            ST_SHIFT: begin
                if (!q.phase) begin
                    n.phase = 1'b1;
                end else begin
                    n.phase = 1'b0;
                    n.sh    = q.sh << 1;
                    if (q.bitc == '0) begin
                        if (gap_val != '0) begin
                            n.st  = ST_GAP;
                            n.cnt = gap_val;
                        end else begin
                            post = 1'b1;
                        end
                    end else begin
                        n.bitc = q.bitc - BW'(1);
                    end
                end
            end
            ST_GAP: begin
                if (q.cnt <= DLYW'(1)) post = 1'b1;
                else                   n.cnt = q.cnt - DLYW'(1);
            end
            ST_HOLD: begin
                if (dis_any) begin
                    rel = 1'b1;
                end else if (q.hold_v) begin
                    if (!tgt_ok) begin
                        n.hold_v = 1'b0;
                    end else if (tgt_idx == q.cur) begin
                        n.hold_v = 1'b0;
                        n.st     = ST_SHIFT;
                        n.sh     = q.hold_data;
                        n.last   = q.hold_last;
                        n.bitc   = BW'(DW - 1);
                        n.phase  = 1'b0;
                    end else begin
                        rel = 1'b1;
                    end
                end
            end
            ST_DESEL: begin
                if (q.cnt <= DLYW'(1)) n.st = ST_IDLE;
                else                   n.cnt = q.cnt - DLYW'(1);
            end
            default: n.st = ST_IDLE;
        endcase

        if (post) begin
            if (!cfg_keep[q.cur] || q.last || dis_any) rel = 1'b1;
            else                                       n.st = ST_HOLD;
        end

        if (rel) begin
            n.dis = 1'b0;
            if (cfg_dly_cs == '0) begin
                n.st = ST_IDLE;
            end else begin
                n.st  = ST_DESEL;
                n.cnt = cfg_dly_cs;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= n;
        end
    end

    logic cs_on;
    assign cs_on    = (q.st == ST_PRE) || (q.st == ST_SHIFT) ||
                      (q.st == ST_GAP) || (q.st == ST_HOLD);
    assign cs_n     = cs_on ? ~(NCS'(1) << q.cur) : '1;
    assign sclk     = (q.st == ST_SHIFT) && q.phase;
    assign mosi     = q.sh[DW-1];
    assign tx_rdy   = !q.hold_v;
    assign tx_empty = !q.hold_v && ((q.st == ST_IDLE) || (q.st == ST_HOLD));

    // R1
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R12
    sclk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> (cs_n != '1));

    // R10
    no_midword_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SHIFT && !(q.phase && q.bitc == '0)) |=> (cs_n == $past(cs_n)));

    // R7
    no_direct_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n) != '1 && cs_n != '1) |-> (cs_n == $past(cs_n)));

    // R5
    fall_without_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n) == '1 && cs_n != '1) |-> !sclk);

    // R11
    empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> (!sclk && tx_rdy));
endmodule

// File: tb/sim_spi_cs_seq.sv
module sim_spi_cs_seq;
    localparam int DW = 8;
    localparam int DL = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_var_sel = 1'b0;
    logic [3:0]    cfg_fixed_cs = 4'hF;
    logic [3:0]    cfg_keep = '0;
    logic [4*DL-1:0] cfg_dly_pre = '0;
    logic [4*DL-1:0] cfg_dly_gap = '0;
    logic [DL-1:0] cfg_dly_cs = '0;
    logic          wr_en = 1'b0;
    logic [DW+4:0] wr_word = '0;
    logic          cmd_dis = 1'b0;
    logic          tx_rdy, tx_empty, sclk, mosi;
    logic [3:0]    cs_n;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    spi_cs_seq #(.DW(DW), .DLYW(DL)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_var_sel(cfg_var_sel),
        .cfg_fixed_cs(cfg_fixed_cs), .cfg_keep(cfg_keep),
        .cfg_dly_pre(cfg_dly_pre), .cfg_dly_gap(cfg_dly_gap),
        .cfg_dly_cs(cfg_dly_cs), .wr_en(wr_en), .wr_word(wr_word),
        .cmd_dis(cmd_dis), .tx_rdy(tx_rdy), .tx_empty(tx_empty),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
    );

    // observation of the serial side
    int cyc, nw, nf, nr, bn, t0;
    int f_t [16];
    int r_t [16];
    int w_t0 [16];
    int w_t1 [16];
    logic [7:0] w_d [16];
    logic [3:0] w_cs [16];
    logic [7:0] bits;
    logic [3:0] prev_cs;

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; nw = 0; nf = 0; nr = 0; bn = 0; t0 = 0;
            prev_cs = 4'hF;
        end else begin
            cyc++;
            if (prev_cs == 4'hF && cs_n != 4'hF && nf < 16) begin f_t[nf] = cyc; nf++; end
            if (prev_cs != 4'hF && cs_n == 4'hF && nr < 16) begin r_t[nr] = cyc; nr++; end
            if (sclk) begin
                bits = {bits[6:0], mosi};
                if (bn == 0) t0 = cyc;
                bn++;
                if (bn == DW) begin
                    if (nw < 16) begin
                        w_d[nw] = bits; w_cs[nw] = cs_n; w_t0[nw] = t0; w_t1[nw] = cyc;
                        nw++;
                    end
                    bn = 0;
                end
            end
            prev_cs = cs_n;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cfg_var_sel = 1'b0; cfg_fixed_cs = 4'hF; cfg_keep = '0;
        cfg_dly_pre = '0; cfg_dly_gap = '0; cfg_dly_cs = '0;
        wr_en = 1'b0; cmd_dis = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_sel(input int i, input int pre, input int gap);
        cfg_dly_pre[i*DL +: DL] = DL'(pre);
        cfg_dly_gap[i*DL +: DL] = DL'(gap);
    endtask

    task automatic send(input bit last, input logic [3:0] sel, input logic [7:0] d);
        for (int t = 0; t < 5000 && !tx_rdy; t++) @(negedge clk);
        wr_word = {last, sel, d};
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_empty();
        for (int t = 0; t < 5000 && !tx_empty; t++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk(cs_n == 4'hF, "R1 reset selects", cs_n, 15);
        chk(sclk == 1'b0, "R12 reset clock", sclk, 0);
        chk(tx_empty && tx_rdy, "R11 reset status", {tx_empty, tx_rdy}, 3);
    endtask

    task automatic t_fixed();
        do_reset();
        cfg_fixed_cs = 4'b1011;
        set_sel(2, 3, 0);
        send(1'b0, 4'b1110, 8'hA5);
        send(1'b0, 4'b1111, 8'h3C);
        wait_empty();
        chk(nw == 2, "R2 word count", nw, 2);
        chk(w_cs[0] == 4'b1011, "R2 fixed target", w_cs[0], 4'b1011);
        chk(w_cs[1] == 4'b1011, "R2 field ignored", w_cs[1], 4'b1011);
        chk(w_d[0] == 8'hA5, "R12 data msb first", w_d[0], 8'hA5);
        chk(w_d[1] == 8'h3C, "R12 second data", w_d[1], 8'h3C);
        chk(w_t0[0] - f_t[0] == 4, "R5 pre delay 3", w_t0[0] - f_t[0], 4);
        chk(nr == 2, "R8 release per word", nr, 2);
        chk(cs_n == 4'hF, "R1 idle high", cs_n, 15);
    endtask

    task automatic t_var();
        do_reset();
        cfg_var_sel = 1'b1;
        cfg_dly_cs = 8'd2;
        send(1'b0, 4'b1110, 8'h81);
        send(1'b0, 4'b1110, 8'h42);
        send(1'b0, 4'b0111, 8'hF0);
        wait_empty();
        chk(nw == 3, "R3 word count", nw, 3);
        chk(w_cs[0] == 4'b1110 && w_cs[1] == 4'b1110, "R3 target 0", w_cs[1], 4'b1110);
        chk(w_cs[2] == 4'b0111, "R3 target 3", w_cs[2], 4'b0111);
        chk(w_d[2] == 8'hF0, "R3 data", w_d[2], 8'hF0);
        chk(nf == 3, "R8 select per word", nf, 3);
        chk(f_t[1] - r_t[0] == 3, "R7 release wait 2", f_t[1] - r_t[0], 3);
        chk(f_t[2] - r_t[1] == 3, "R7 switch wait 2", f_t[2] - r_t[1], 3);
        chk(w_t0[0] - f_t[0] == 2, "R5 pre zero gives one", w_t0[0] - f_t[0], 2);
    endtask

    task automatic t_invalid();
        do_reset();
        cfg_var_sel = 1'b1;
        send(1'b0, 4'b1100, 8'hFF);
        send(1'b0, 4'b1111, 8'hFF);
        wait_empty();
        chk(nf == 0, "R4 no select", nf, 0);
        chk(nw == 0, "R4 no clock", nw, 0);
        chk(tx_empty == 1'b1, "R4 empty after drop", tx_empty, 1);
    endtask

    task automatic t_keep();
        do_reset();
        cfg_var_sel = 1'b1;
        cfg_keep = 4'b0010;
        set_sel(1, 1, 4);
        send(1'b0, 4'b1101, 8'h11);
        send(1'b0, 4'b1101, 8'h22);
        send(1'b1, 4'b1101, 8'h33);
        wait_empty();
        chk(nw == 3, "R6 words", nw, 3);
        chk(nf == 1, "R6 single fall", nf, 1);
        chk(w_t0[1] - w_t1[0] == 7, "R6 gap 4", w_t0[1] - w_t1[0], 7);
        chk(nr == 1 && cs_n == 4'hF, "R9 last releases", nr, 1);
        chk(w_d[2] == 8'h33, "R9 last data", w_d[2], 8'h33);
        set_sel(1, 1, 0);
        send(1'b0, 4'b1101, 8'h44);
        send(1'b1, 4'b1101, 8'h55);
        wait_empty();
        chk(w_t0[4] - w_t1[3] == 3, "R6 gap 0", w_t0[4] - w_t1[3], 3);
    endtask

    task automatic t_dis_hold();
        do_reset();
        cfg_var_sel = 1'b1;
        cfg_keep = 4'b0001;
        send(1'b0, 4'b1110, 8'h5A);
        wait_empty();
        chk(cs_n == 4'b1110, "R11 empty while held", cs_n, 4'b1110);
        cmd_dis = 1'b1;
        @(negedge clk);
        cmd_dis = 1'b0;
        chk(cs_n == 4'hF, "R10 release from hold", cs_n, 15);
        chk(nw == 1, "R10 no extra clock", nw, 1);
    endtask

    task automatic t_dis_last_bit();
        int seen;
        do_reset();
        cfg_var_sel = 1'b1;
        cfg_keep = 4'b0100;
        send(1'b0, 4'b1011, 8'hC3);
        seen = 0;
        for (int t = 0; t < 500 && seen < DW; t++) begin
            if (sclk) seen++;
            if (seen < DW) @(negedge clk);
        end
        cmd_dis = 1'b1;
        @(negedge clk);
        cmd_dis = 1'b0;
        chk(cs_n == 4'hF, "R10 disable on final phase", cs_n, 15);
        repeat (3) @(negedge clk);
        chk(nw == 1 && w_d[0] == 8'hC3, "R10 word complete", w_d[0], 8'hC3);
    endtask

    task automatic t_full();
        do_reset();
        cfg_var_sel = 1'b1;
        send(1'b0, 4'b1110, 8'h01);
        send(1'b0, 4'b1110, 8'h02);
        chk(tx_rdy == 1'b0, "R11 ready low when full", tx_rdy, 0);
        chk(tx_empty == 1'b0, "R11 empty low when busy", tx_empty, 0);
        wr_word = {1'b0, 4'b0111, 8'hEE};
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        wait_empty();
        chk(nw == 2, "R11 full write ignored", nw, 2);
        chk(w_d[1] == 8'h02 && w_cs[1] == 4'b1110, "R11 pending kept", w_d[1], 8'h02);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_fixed();
        t_var();
        t_invalid();
        t_keep();
        t_dis_hold();
        t_dis_last_bit();
        t_full();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule